// File: doc/BRIEF.md
# Serial-In Overwriting Word FIFO

The block turns a framed serial bit stream into parallel words and queues them in a 256-entry memory. A one-cycle Start pulse marks the first bit of each word. Eight bits are collected, least significant bit first, and the finished word is appended to the queue. The memory has a registered read port, so it maps onto on-chip block RAM.

A consumer raises the read input for one cycle per word. Each accepted read places the oldest stored word on the output register one clock later. The block never stalls the sender. If a word completes while the queue already holds 256 entries and no read is taken in that cycle, the oldest unread entry is dropped to make room.

Top module: `serial_word_fifo`

## Requirements
- R1: After reset the queue is empty and `data_o` is zero.
- R2: The bit sampled together with `start_i` is bit 0 of the word. The bits sampled on the next 7 clock edges fill bits 1 to 7 in ascending order.
- R3: A word is committed on the clock edge after its eighth bit is sampled. A read sampled on that commit edge with the queue otherwise empty returns nothing. A read on the following edge returns the word.
- R4: Words are returned in the order they were assembled, under any mix of serial input and reads.
- R5: `data_o` changes only on an edge that samples `read_i` high with stored data. Otherwise it holds its value.
- R6: A read while the queue is empty consumes nothing, and the word order that follows is unaffected. `data_o` is undefined after such a read.
- R7: When a word completes with 256 entries stored and no read taken in that cycle, the oldest entry is discarded and the count stays at 256.
- R8: Bits on `data_i` with no preceding `start_i` are ignored and create no word.
- R9: A `start_i` before the eighth bit of the current word restarts assembly. The partial word is discarded.
- R10: On a full queue, a read and a commit on the same edge return the oldest word and leave the queue full with the new word at its tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse marking bit 0 of a word |
| data_i | input | 1 | Serial data bit |
| read_i | input | 1 | Read request, one word per cycle |
| data_o | output | WORD_W | Registered word from the queue head |

## Verification
Single words with distinct bit patterns show whether bit order and framing are correct. Toggling data with no Start, and Starts that cut a word short, separate ignored bits from restarted assembly. Writing 260 words with no reads, and a read coinciding with a commit on a full queue, separate overwrite-oldest from dropping or blocking. A long random mix of framing, aborts and reads, checked against a queue model, exposes ordering and pointer errors, including reads at the exact commit edge.

// File: rtl/serial_word_fifo.sv
module serial_word_fifo #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              data_i,
  input  logic              read_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] TOP_PTR  = AW'(DEPTH - 1);

  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     bitcnt;
  logic              busy, commit;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic [WORD_W-1:0] mem [DEPTH];

  wire empty     = (count == '0);
  wire full      = (count == FULL_CNT);
  wire do_read   = read_i && !empty;
  wire overwrite = commit && full && !do_read;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == TOP_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      busy   <= 1'b0;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start_i) begin
        shreg  <= {data_i, shreg[WORD_W-1:1]};
        bitcnt <= BW'(1);
        busy   <= 1'b1;
      end else if (busy) begin
        shreg  <= {data_i, shreg[WORD_W-1:1]};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == LAST_BIT) begin
          busy   <= 1'b0;
          commit <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[wr_ptr] <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_read) data_o <= mem[rd_ptr];
      if (commit) wr_ptr <= bump(wr_ptr);
      if (do_read || overwrite) rd_ptr <= bump(rd_ptr);
      if (commit && !do_read && !full) count <= count + 1'b1;
      else if (do_read && !commit)     count <= count - 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R7
  AST_OVERWRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overwrite |=> full); // R7
  AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (read_i && empty && !commit) |=> (empty && $stable(rd_ptr))); // R6
  AST_COMMIT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (wr_ptr != $past(wr_ptr))); // R3
  AST_RESTART_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !commit); // R9
  AST_FULL_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && full && read_i) |=> full); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !read_i |=> $stable(data_o)); // R5
endmodule

// File: tb/serial_word_fifo_tb_top.sv
module serial_word_fifo_tb_top;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, data_i = 1'b0, read_i = 1'b0;
  logic [7:0] data_o;

  serial_word_fifo #(.WORD_W(8), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .read_i(read_i), .data_o(data_o));

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [7:0] q[$];
  logic [7:0] m_acc, m_done, last;
  int m_n = 0;
  bit m_act = 0, m_pend = 0, last_ok = 0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: data_o=%02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic d, input logic r, input string tag);
    logic [7:0] exp;
    bit got, nxt;
    start_i = s; data_i = d; read_i = r;
    @(posedge clk);
    got = 0;
    if (r && q.size() > 0) begin exp = q.pop_front(); got = 1; end
    if (m_pend) begin
      if (q.size() == DEPTH) void'(q.pop_front());
      q.push_back(m_done);
    end
    nxt = 0;
    if (s) begin
      m_acc = 8'h00; m_acc[0] = d; m_n = 1; m_act = 1;
    end else if (m_act) begin
      m_acc[m_n] = d; m_n++;
      if (m_n == 8) begin m_act = 0; nxt = 1; m_done = m_acc; end
    end
    m_pend = nxt;
    @(negedge clk);
    if (got) begin check(data_o, exp, tag); last = exp; last_ok = 1; end
    else if (r) last_ok = 0;
    else if (last_ok) check(data_o, last, "R5");
  endtask

  task automatic send_word(input logic [7:0] w, input string tag);
    for (int i = 0; i < 8; i++) step(i == 0, w[i], 1'b0, tag);
  endtask

  task automatic drain(input string tag);
    step(1'b0, 1'b0, 1'b0, tag);
    while (q.size() > 0 || m_pend) step(1'b0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_o, 8'h00, "R1");

    send_word(8'hA5, "R2"); drain("R2");
    send_word(8'h01, "R2"); drain("R2");
    send_word(8'h80, "R2"); drain("R2");

    send_word(8'h3C, "R3");
    step(1'b0, 1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b1, "R3");
    repeat (4) step(1'b0, 1'b0, 1'b0, "R5");

    for (int i = 0; i < 20; i++) step(1'b0, i[0], 1'b0, "R8");
    send_word(8'h11, "R8"); drain("R8");

    step(1'b1, 1'b1, 1'b0, "R9"); step(1'b0, 1'b1, 1'b0, "R9"); step(1'b0, 1'b1, 1'b0, "R9");
    send_word(8'h96, "R9"); drain("R9");
    send_word(8'h42, "R9"); drain("R9");

    repeat (3) step(1'b0, 1'b0, 1'b1, "R6");
    send_word(8'h5A, "R6"); send_word(8'hC3, "R6"); drain("R6");

    for (int k = 0; k < 260; k++) send_word(k[7:0], "R7");
    drain("R7");
    send_word(8'h77, "R7"); drain("R7");

    for (int k = 0; k < DEPTH; k++) send_word(8'(k * 7), "R10");
    send_word(8'hEE, "R10");
    step(1'b0, 1'b0, 1'b1, "R10");
    drain("R10");

    for (int c = 0; c < 3000; c++)
      step(($urandom % 12) == 0, 1'($urandom), ($urandom % 3) == 0, "R4");
    drain("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule